// File: doc/BRIEF.md
# Two-Level Lookahead Adder with Bounded Gate Width

This block adds two unsigned operands and a carry-in in purely combinational logic, giving a sum and a carry-out. No carry is rippled from bit to bit. Each bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). Every internal carry is then built as a sum of products from those terms and the incoming carry. No product or sum in the design is wider than five inputs.

To stay inside that limit, the bits are split into groups of four. Each group derives its internal carries from its own generate and propagate terms and from the carry into the group. Each group also gives a group generate and a group propagate. A second lookahead unit of the same shape uses those to form the carry into each upper group and the final carry-out. With the default parameters the adder is 8 bits wide: two groups of four, plus a two-input group-level stage. The block has no clock and no reset, and its outputs follow its inputs.

Top module: `cla8_adder`

## Requirements
- R1: For every input combination, {carry_out, sum_o} equals op_a + op_b + carry_in, with all values taken as unsigned.
- R2: The carry into bit 4, the lowest bit of the upper group, equals the carry-out of op_a[3:0] + op_b[3:0] + carry_in. For example, 0x0F + 0x01 gives sum 0x10.
- R3: When op_a ^ op_b is all ones, carry_out equals carry_in. In that case sum_o is all ones when carry_in is 0 and all zeros when carry_in is 1.
- R4: When both operands are all ones, carry_out is 1 and sum_o is 0xFE + carry_in (0xFE or 0xFF).
- R5: When op_b is zero and carry_in is 0, sum_o equals op_a and carry_out is 0.
- R6: The outputs depend on the present inputs only, with no clock and no stored state. All-zero inputs give sum_o 0x00 and carry_out 0, and a new input value is reflected within the same time step.
- R7: The carry a group produces from its own lookahead equals the carry that the group-level lookahead gives to the next group, and the top group's carry equals carry_out. Carries that cross the group boundary, such as 0x7F + 0x01 = 0x80 and 0xF0 + 0x10 = 0x00 with carry_out 1, come out right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 8 | Sum, modulo 2^8 |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder with its defaults: a group width of 4 and two groups. At that width the whole input space is only 2^17 points, so every operand pair with both carry-in values is compared against a plain reference addition. That sweep reaches every product term of both lookahead levels, including the group-boundary carry and the full-propagate path from carry_in to carry_out. A short table of named corner vectors runs first, so that a failure points to a specific requirement.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Widest AND/OR term any gate may have.
  localparam int MAX_FANIN = 5;
  // Largest lookahead span whose top carry stays within MAX_FANIN terms.
  localparam int MAX_SPAN  = MAX_FANIN - 1;
endpackage

// File: rtl/bit_pg.sv
module bit_pg #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/la_unit.sv
// Carry lookahead over SPAN positions: carry_o[i] is the carry out of
// position i, as an OR of (i+2) product terms, the widest having i+2 inputs.
module la_unit #(
  parameter int SPAN = 4
) (
  input  logic [SPAN-1:0] gen_i,
  input  logic [SPAN-1:0] prop_i,
  input  logic            cin_i,
  output logic [SPAN-1:0] carry_o
);
  always_comb begin
    logic acc;
    logic term;
    for (int i = 0; i < SPAN; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i + 1; j++) begin
        term = (j == 0) ? cin_i : gen_i[j-1];
        for (int k = j; k <= i; k++) begin
          term = term & prop_i[k];
        end
        acc = acc | term;
      end
      carry_o[i] = acc;
    end
  end
endmodule

// File: rtl/grp_pg.sv
// Group generate and propagate for one group of SPAN bits.
module grp_pg #(
  parameter int SPAN = 4
) (
  input  logic [SPAN-1:0] gen_i,
  input  logic [SPAN-1:0] prop_i,
  output logic            grp_gen_o,
  output logic            grp_prop_o
);
  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < SPAN; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < SPAN; k++) begin
        term = term & prop_i[k];
      end
      acc = acc | term;
    end
    grp_gen_o = acc;
    term = 1'b1;
    for (int k = 0; k < SPAN; k++) begin
      term = term & prop_i[k];
    end
    grp_prop_o = term;
  end
endmodule

// File: rtl/cla8_adder.sv
module cla8_adder #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 2,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  logic [WIDTH-1:0]      gen;
  logic [WIDTH-1:0]      prop;
  logic [WIDTH-1:0]      bit_cin;
  logic [NUM_GROUPS-1:0] grp_gen;
  logic [NUM_GROUPS-1:0] grp_prop;
  logic [NUM_GROUPS-1:0] grp_cout;
  logic [NUM_GROUPS:0]   grp_cin;

  bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i   (op_a),
    .b_i   (op_b),
    .gen_o (gen),
    .prop_o(prop)
  );

  assign grp_cin[0] = carry_in;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    logic [GROUP_W-1:0] grp_carry;

    la_unit #(.SPAN(GROUP_W)) u_la (
      .gen_i  (gen[k*GROUP_W +: GROUP_W]),
      .prop_i (prop[k*GROUP_W +: GROUP_W]),
      .cin_i  (grp_cin[k]),
      .carry_o(grp_carry)
    );

    grp_pg #(.SPAN(GROUP_W)) u_gpg (
      .gen_i     (gen[k*GROUP_W +: GROUP_W]),
      .prop_i    (prop[k*GROUP_W +: GROUP_W]),
      .grp_gen_o (grp_gen[k]),
      .grp_prop_o(grp_prop[k])
    );

    assign bit_cin[k*GROUP_W] = grp_cin[k];
    if (GROUP_W > 1) begin : g_inner
      assign bit_cin[k*GROUP_W+1 +: GROUP_W-1] = grp_carry[GROUP_W-2:0];
    end
    assign grp_cout[k] = grp_carry[GROUP_W-1];
  end

  la_unit #(.SPAN(NUM_GROUPS)) u_top (
    .gen_i  (grp_gen),
    .prop_i (grp_prop),
    .cin_i  (carry_in),
    .carry_o(grp_cin[NUM_GROUPS:1])
  );

  assign sum_o     = prop ^ bit_cin;
  assign carry_out = grp_cin[NUM_GROUPS];
endmodule

// File: rtl/cla8_adder_chk.sv
module cla8_adder_chk #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 2,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input logic [WIDTH-1:0]      op_a,
  input logic [WIDTH-1:0]      op_b,
  input logic                  carry_in,
  input logic [WIDTH-1:0]      sum_o,
  input logic                  carry_out,
  input logic [NUM_GROUPS:0]   grp_cin,
  input logic [NUM_GROUPS-1:0] grp_cout
);
  logic [WIDTH:0]   ref_full;
  logic [GROUP_W:0] ref_low;

  always_comb begin
    ref_full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    ref_low  = {1'b0, op_a[GROUP_W-1:0]} + {1'b0, op_b[GROUP_W-1:0]}
             + {{GROUP_W{1'b0}}, carry_in};

    AST_SUM_MATCH: assert ({carry_out, sum_o} == ref_full); // R1
    AST_LOW_GROUP_CARRY: assert (grp_cin[1] == ref_low[GROUP_W]); // R2
    if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
      AST_FULL_PROPAGATE: assert (carry_out == carry_in && sum_o == {WIDTH{~carry_in}}); // R3
    end
    if (op_a == {WIDTH{1'b1}} && op_b == {WIDTH{1'b1}}) begin
      AST_ALL_ONES: assert (carry_out && sum_o[WIDTH-1:1] == {(WIDTH-1){1'b1}} && sum_o[0] == carry_in); // R4
    end
    if (op_b == '0 && !carry_in) begin
      AST_ZERO_IDENTITY: assert (sum_o == op_a && !carry_out); // R5
    end
    for (int k = 0; k < NUM_GROUPS - 1; k++) begin
      AST_GROUP_AGREE: assert (grp_cout[k] == grp_cin[k+1]); // R7
    end
    AST_TOP_CARRY: assert (grp_cout[NUM_GROUPS-1] == carry_out); // R7
  end
endmodule

bind cla8_adder cla8_adder_chk #(
  .GROUP_W   (GROUP_W),
  .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .sum_o    (sum_o),
  .carry_out(carry_out),
  .grp_cin  (grp_cin),
  .grp_cout (grp_cout)
);

// File: tb/cla8_adder_tb.sv
module cla8_adder_tb;
  logic       clk = 1'b0;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic       carry_in = 1'b0;
  logic [7:0] sum_o;
  logic       carry_out;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cla8_adder u_dut (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_o    (sum_o),
    .carry_out(carry_out)
  );

  // {a, b, cin, expected cout, expected sum}
  localparam int NVEC = 12;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00},  // R6 all-zero inputs
    {8'h0F, 8'h01, 1'b0, 1'b0, 8'h10},  // R2
    {8'h0F, 8'h00, 1'b1, 1'b0, 8'h10},  // R2
    {8'hA5, 8'h5A, 1'b0, 1'b0, 8'hFF},  // R3
    {8'hA5, 8'h5A, 1'b1, 1'b1, 8'h00},  // R3
    {8'hFF, 8'hFF, 1'b0, 1'b1, 8'hFE},  // R4
    {8'hFF, 8'hFF, 1'b1, 1'b1, 8'hFF},  // R4
    {8'h3C, 8'h00, 1'b0, 1'b0, 8'h3C},  // R5
    {8'h80, 8'h80, 1'b0, 1'b1, 8'h00},  // R7
    {8'h7F, 8'h01, 1'b0, 1'b0, 8'h80},  // R7
    {8'hF0, 8'h10, 1'b0, 1'b1, 8'h00},  // R7
    {8'h12, 8'h34, 1'b1, 1'b0, 8'h47}   // R1
  };
  localparam string VEC_REQ [NVEC] = '{
    "R6", "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R7", "R7", "R7", "R1"
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
               req, op_a, op_b, carry_in, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    // Table walk: drive, let settle, sample away from any clock edge.
    for (int v = 0; v < NVEC; v++) begin
      {op_a, op_b, carry_in} = VEC[v][25:9];
      #1;
      check(VEC_REQ[v], {carry_out, sum_o}, VEC[v][8:0]);
      #1;
    end

    // R6: change inputs mid-cycle and see the output follow at once.
    @(negedge clk);
    op_a = 8'h01; op_b = 8'h01; carry_in = 1'b1;
    #1;
    check("R6", {carry_out, sum_o}, 9'h003);
    op_a = 8'h00; op_b = 8'h00; carry_in = 1'b0;
    #1;
    check("R6", {carry_out, sum_o}, 9'h000);

    // R1: exhaustive sweep against a plain addition.
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          op_a = 8'(a); op_b = 8'(b); carry_in = 1'(ci);
          #1;
          check("R1", {carry_out, sum_o}, 9'(a + b + ci));
        end
      end
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule